// File: doc/BRIEF.md
# Shared Microcode RAM with Host and Coprocessor Ownership

This block is a word-organised RAM that has two owners in turn. In normal mode a host register bus reads and writes it at byte, halfword or word width, and so loads a timer program into it. When one or both timer coprocessors raise their emulation enable, the array is taken from the host. It then serves word-wide instruction fetches on one auxiliary read port per coprocessor, and both ports may fetch in the same cycle.

A configuration register holds a stop bit and a disable bit, and it reports a refused stop request and the live emulation state. Stop mode is modelled as a block on array access. The register side stays reachable, so software can clear the stop bit again, and the array keeps its contents. The block will not enter stop while any emulation enable is high. A synchronous reset lets a host access that is already accepted finish cleanly and blocks every request after it. A freeze input is accepted and has no effect.

Top module: `smr_ram`

## Requirements
- R1: In normal mode, with h_addr[AW+2]=0, a host write updates only the byte lanes it selects. Sizes: h_size 0 is a byte on lane h_addr[1:0], 1 is a halfword on lanes {h_addr[1],0} and {h_addr[1],1}, 2 is a word. Lane n holds bits [8n+7:8n]. A read returns the whole addressed word. Every accepted request gets h_ack=1 two rising edges after the edge that samples it, with h_err=0.
- R2: A halfword with h_addr[0]=1, a word with h_addr[1:0]!=0, and h_size=3 all return h_err=1 and change nothing. Every response with h_err=1 carries h_rdata=0.
- R3: h_addr[AW+2]=1 selects the registers, indexed by h_addr[AW+1:2]. Index 0 is the configuration register: bit 0 STOP, bit 1 DIS, bit 2 REFUSED (read-only), bit 3 EMU (read-only, the OR of emu_en), all other bits 0, and it resets to 0. A write changes it only when byte lane 0 is selected; other lanes are ignored without error. Index 1 reads as the array depth in words. Writes to index 1, and any access to an index of 2 or more, return h_err=1.
- R4: While DIS=1, array accesses return h_err=1, reads give 0 and writes have no effect.
- R5: While STOP=1, array accesses and index-1 accesses return h_err=1 and the array keeps its contents. The configuration register stays readable and writable, but a write changes only STOP and leaves DIS as it was. No fetch port returns valid.
- R6: A configuration write with bit 0 set while any emu_en bit is high leaves STOP at 0 and sets REFUSED. Any other accepted write to the configuration register clears REFUSED.
- R7: While any emu_en bit is high, host array accesses return h_err=1. Fetch port i sets f_valid[i] one edge after f_req[i], with f_data slice i holding the word at its address. This happens only when emu_en[i]=1 and STOP=0; otherwise f_valid[i]=0 and the slice is 0. Both ports can return data in the same cycle.
- R8: A host request sampled before rst rises still completes while rst is high: it is acked with h_err=0 and its write lands. Requests presented while rst is high get no ack and write nothing. Reset clears the configuration register but does not clear the array.
- R9: The freeze input has no effect on any response, fetch or register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host request strobe, one cycle per access |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| h_addr | input | AW+3 | Byte address; top bit selects the register space |
| h_wdata | input | 32 | Write data, byte lanes aligned to the address |
| h_ack | output | 1 | Response strobe |
| h_err | output | 1 | Error response |
| h_rdata | output | 32 | Read data, the whole word |
| emu_en | input | NFETCH | Per-coprocessor emulation enable |
| freeze | input | 1 | Debug freeze; no effect |
| f_req | input | NFETCH | Per-port fetch request |
| f_addr | input | NFETCH*AW | Per-port word address, port 0 in the low bits |
| f_valid | output | NFETCH | Per-port fetch data valid |
| f_data | output | NFETCH*32 | Per-port fetched word, port 0 in the low bits |

## Verification
A wrong ownership or stop state shows up at the latest on the second edge after the next host request: an ack then carries the wrong h_err, or read data that should have been zero. A fetch issued in that state shows the fault one edge after its request, through f_valid. A write that lands when it should have been blocked stays hidden until the word is read back. For that reason the bench reads words back after every blocked phase and after the mid-access reset, and the configuration register is read after each change so that the STOP, DIS and REFUSED bits are seen directly.

// File: rtl/smr_pkg.sv
package smr_pkg;

    localparam int DW = 32;
    localparam int NB = DW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // configuration register bit positions
    localparam int CB_STOP    = 0;
    localparam int CB_DIS     = 1;
    localparam int CB_REFUSED = 2;
    localparam int CB_EMU     = 3;

    typedef struct packed {
        logic stop;
        logic dis;
        logic refused;
    } ctrl_t;

    function automatic logic size_aligned(input acc_size_e sz, input logic [1:0] lo);
        logic ok;
        case (sz)
            SZ_BYTE: ok = 1'b1;
            SZ_HALF: ok = ~lo[0];
            SZ_WORD: ok = (lo == 2'b00);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [NB-1:0] lane_mask(input acc_size_e sz, input logic [1:0] lo);
        logic [NB-1:0] m;
        m = '0;
        case (sz)
            SZ_BYTE: m[lo] = 1'b1;
            SZ_HALF: begin
                m[{lo[1], 1'b0}] = 1'b1;
                m[{lo[1], 1'b1}] = 1'b1;
            end
            SZ_WORD: m = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/smr_array.sv
module smr_array
    import smr_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NRD = 2
) (
    input  logic                clk,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [NB-1:0]       wbe,
    input  logic [DW-1:0]       wdata,
    input  logic [AW-1:0]       haddr,
    output logic [DW-1:0]       hdata,
    input  logic [NRD*AW-1:0]   raddr,
    output logic [NRD*DW-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (wbe[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign hdata = mem[haddr];

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g*DW +: DW] = mem[raddr[g*AW +: AW]];
    end

    // R1: the host side never issues a write with no lane selected
    always_comb begin
        if (we) begin
            a_r1_write_has_lanes: assert (wbe != '0)
                else $error("array write with empty lane mask");
        end
    end

endmodule

// File: rtl/smr_host.sv
module smr_host
    import smr_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_wr,
    input  logic [1:0]        h_size,
    input  logic [AW+2:0]     h_addr,
    input  logic [DW-1:0]     h_wdata,
    input  logic              emu_any,
    output logic              h_ack,
    output logic              h_err,
    output logic [DW-1:0]     h_rdata,
    output logic              stop_o,
    output logic              mw_en,
    output logic [AW-1:0]     mw_addr,
    output logic [NB-1:0]     mw_be,
    output logic [DW-1:0]     mw_data,
    output logic [AW-1:0]     mr_addr,
    input  logic [DW-1:0]     mr_data
);
    localparam int HAW = AW + 3;

    typedef struct packed {
        logic          valid;
        logic          wr;
        logic          err;
        logic          is_reg;
        logic          is_cfg;
        logic [AW-1:0] word;
        logic [NB-1:0] be;
        logic [DW-1:0] wdata;
    } pend_t;

    pend_t     pend_q, pend_d;
    ctrl_t     ctrl_q;

    logic          dec_reg, dec_cfg, dec_info, dec_bad;
    logic [AW-1:0] dec_word;
    acc_size_e     dec_size;

    // request decode, judged against the state in force at the sampling edge
    always_comb begin
        dec_size = acc_size_e'(h_size);
        dec_word = h_addr[AW+1:2];
        dec_reg  = h_addr[HAW-1];
        dec_cfg  = dec_reg && (dec_word == '0);
        dec_info = dec_reg && (dec_word == AW'(1));
        if (!size_aligned(dec_size, h_addr[1:0]))
            dec_bad = 1'b1;
        else if (dec_reg)
            dec_bad = !(dec_cfg || (dec_info && !h_wr && !ctrl_q.stop));
        else
            dec_bad = ctrl_q.stop || ctrl_q.dis || emu_any;
    end

    always_comb begin
        pend_d.valid  = h_req;
        pend_d.wr     = h_wr;
        pend_d.err    = dec_bad;
        pend_d.is_reg = dec_reg;
        pend_d.is_cfg = dec_cfg;
        pend_d.word   = dec_word;
        pend_d.be     = lane_mask(dec_size, h_addr[1:0]);
        pend_d.wdata  = h_wdata;
    end

    // a held request is never cancelled by reset: it commits on the reset edge
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign mw_en   = pend_q.valid && pend_q.wr && !pend_q.err && !pend_q.is_reg;
    assign mw_addr = pend_q.word;
    assign mw_be   = pend_q.be;
    assign mw_data = pend_q.wdata;
    assign mr_addr = pend_q.word;

    logic cfg_wr, stop_req;
    assign cfg_wr   = pend_q.valid && pend_q.wr && !pend_q.err && pend_q.is_cfg && pend_q.be[0];
    assign stop_req = pend_q.wdata[CB_STOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cfg_wr) begin
            ctrl_q.stop    <= stop_req && !emu_any;
            ctrl_q.refused <= stop_req && emu_any;
            if (!ctrl_q.stop) ctrl_q.dis <= pend_q.wdata[CB_DIS];
        end
    end

    logic [DW-1:0] cfg_word, rd_val;

    always_comb begin
        cfg_word             = '0;
        cfg_word[CB_STOP]    = ctrl_q.stop;
        cfg_word[CB_DIS]     = ctrl_q.dis;
        cfg_word[CB_REFUSED] = ctrl_q.refused;
        cfg_word[CB_EMU]     = emu_any;
    end

    always_comb begin
        rd_val = '0;
        if (pend_q.valid && !pend_q.err && !pend_q.wr) begin
            if (!pend_q.is_reg)     rd_val = mr_data;
            else if (pend_q.is_cfg) rd_val = cfg_word;
            else                    rd_val = DW'(DEPTH);
        end
    end

    always_ff @(posedge clk) begin
        h_ack   <= pend_q.valid;
        h_err   <= pend_q.valid && pend_q.err;
        h_rdata <= rd_val;
    end

    assign stop_o = ctrl_q.stop;

    // R2: an error response never carries data
    a_r2_err_data_zero: assert property (@(posedge clk) disable iff (rst)
        (h_ack && h_err) |-> (h_rdata == '0));

    // R6: stop is never entered while a coprocessor owns the array
    a_r6_no_stop_under_emu: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.stop) |-> !$past(emu_any));

    // R8: an ack always answers a request made two edges earlier
    a_r8_ack_after_request: assert property (@(posedge clk) disable iff (rst)
        h_ack |-> $past(h_req, 2));

endmodule

// File: rtl/smr_fetch.sv
module smr_fetch
    import smr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            en,
    input  logic            stop,
    input  logic [AW-1:0]   addr,
    output logic [AW-1:0]   rd_addr,
    input  logic [DW-1:0]   rd_data,
    output logic            valid,
    output logic [DW-1:0]   data
);
    logic grant;

    assign rd_addr = addr;
    assign grant   = req && en && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= grant;
            data  <= grant ? rd_data : '0;
        end
    end

    // R7: a valid fetch needs a request, its own enable, and no stop
    a_r7_fetch_granted: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(req && en && !stop));

endmodule

// File: rtl/smr_ram.sv
module smr_ram
    import smr_pkg::*;
#(
    parameter int AW     = 6,
    parameter int NFETCH = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   h_req,
    input  logic                   h_wr,
    input  logic [1:0]             h_size,
    input  logic [AW+2:0]          h_addr,
    input  logic [31:0]            h_wdata,
    output logic                   h_ack,
    output logic                   h_err,
    output logic [31:0]            h_rdata,
    input  logic [NFETCH-1:0]      emu_en,
    input  logic                   freeze,
    input  logic [NFETCH-1:0]      f_req,
    input  logic [NFETCH*AW-1:0]   f_addr,
    output logic [NFETCH-1:0]      f_valid,
    output logic [NFETCH*32-1:0]   f_data
);
    localparam int DEPTH = 1 << AW;

    logic                  emu_any, stop_w, mw_en;
    logic [AW-1:0]         mw_addr, mr_addr;
    logic [NB-1:0]         mw_be;
    logic [DW-1:0]         mw_data, mr_data;
    logic [NFETCH*AW-1:0]  fr_addr;
    logic [NFETCH*DW-1:0]  fr_data;

    assign emu_any = |emu_en;

    smr_host #(.AW(AW), .DEPTH(DEPTH)) u_host (
        .clk     (clk),
        .rst     (rst),
        .h_req   (h_req),
        .h_wr    (h_wr),
        .h_size  (h_size),
        .h_addr  (h_addr),
        .h_wdata (h_wdata),
        .emu_any (emu_any),
        .h_ack   (h_ack),
        .h_err   (h_err),
        .h_rdata (h_rdata),
        .stop_o  (stop_w),
        .mw_en   (mw_en),
        .mw_addr (mw_addr),
        .mw_be   (mw_be),
        .mw_data (mw_data),
        .mr_addr (mr_addr),
        .mr_data (mr_data)
    );

    smr_array #(.AW(AW), .NRD(NFETCH)) u_array (
        .clk   (clk),
        .we    (mw_en),
        .waddr (mw_addr),
        .wbe   (mw_be),
        .wdata (mw_data),
        .haddr (mr_addr),
        .hdata (mr_data),
        .raddr (fr_addr),
        .rdata (fr_data)
    );

    for (genvar g = 0; g < NFETCH; g++) begin : g_port
        smr_fetch #(.AW(AW)) u_fetch (
            .clk     (clk),
            .rst     (rst),
            .req     (f_req[g]),
            .en      (emu_en[g]),
            .stop    (stop_w),
            .addr    (f_addr[g*AW +: AW]),
            .rd_addr (fr_addr[g*AW +: AW]),
            .rd_data (fr_data[g*DW +: DW]),
            .valid   (f_valid[g]),
            .data    (f_data[g*DW +: DW])
        );
    end

    // R9: with no host request behind it, freeze never moves the stop state
    a_r9_freeze_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (freeze && !$past(h_req)) |=> $stable(stop_w));

endmodule

// File: tb/smr_ram_test.sv
module smr_ram_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req = 1'b0, h_wr = 1'b0;
    logic [1:0]  h_size = 2'd0;
    logic [8:0]  h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ack, h_err;
    logic [31:0] h_rdata;
    logic [1:0]  emu_en = 2'b00;
    logic        freeze = 1'b0;
    logic [1:0]  f_req = 2'b00;
    logic [11:0] f_addr = '0;
    logic [1:0]  f_valid;
    logic [63:0] f_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem_m [64];
    logic        m_stop = 1'b0, m_dis = 1'b0, m_ref = 1'b0;

    always #4ns clk = ~clk;

    smr_ram uut (
        .clk(clk), .rst(rst), .h_req(h_req), .h_wr(h_wr), .h_size(h_size),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_ack(h_ack), .h_err(h_err),
        .h_rdata(h_rdata), .emu_en(emu_en), .freeze(freeze), .f_req(f_req),
        .f_addr(f_addr), .f_valid(f_valid), .f_data(f_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected response from the requirements; updates the model state
    function automatic void model(input logic wr, input logic [1:0] sz, input logic [8:0] a,
                                  input logic [31:0] wd, output logic eerr, output logic [31:0] erd);
        logic [5:0] w;
        logic [1:0] lo;
        logic       al, emu, old_stop, lane;
        w   = a[7:2];
        lo  = a[1:0];
        emu = |emu_en;
        al  = (sz == 2'd0) || (sz == 2'd1 && !lo[0]) || (sz == 2'd2 && lo == 2'd0);
        eerr = 1'b0;
        erd  = '0;
        if (!al) begin
            eerr = 1'b1;
        end else if (a[8]) begin
            if (w == 6'd0) begin
                if (wr) begin
                    if (lo == 2'd0) begin
                        old_stop = m_stop;
                        m_stop = wd[0] & !emu;
                        m_ref  = wd[0] & emu;
                        if (!old_stop) m_dis = wd[1];
                    end
                end else begin
                    erd = {28'd0, emu, m_ref, m_dis, m_stop};
                end
            end else if (w == 6'd1 && !wr && !m_stop) begin
                erd = 32'd64;
            end else begin
                eerr = 1'b1;
            end
        end else if (m_stop || m_dis || emu) begin
            eerr = 1'b1;
        end else if (wr) begin
            for (int b = 0; b < 4; b++) begin
                lane = (sz == 2'd2) || (sz == 2'd1 && b[1] == lo[1]) || (sz == 2'd0 && b[1:0] == lo);
                if (lane) mem_m[w][8*b +: 8] = wd[8*b +: 8];
            end
        end else begin
            erd = mem_m[w];
        end
    endfunction

    task automatic op(input logic wr, input logic [1:0] sz, input logic [8:0] a,
                      input logic [31:0] wd, input string tag);
        logic eerr, ack, err;
        logic [31:0] erd, rd;
        model(wr, sz, a, wd, eerr, erd);
        @(negedge clk);
        h_req = 1'b1; h_wr = wr; h_size = sz; h_addr = a; h_wdata = wd;
        @(negedge clk);
        h_req = 1'b0;
        @(negedge clk);
        ack = h_ack; err = h_err; rd = h_rdata;
        check(ack === 1'b1 && err === eerr && rd === erd, tag,
              {30'd0, ack, err, rd}, {30'd0, 1'b1, eerr, erd});
    endtask

    task automatic fetch(input logic [1:0] rq, input logic [5:0] a0, input logic [5:0] a1, input string tag);
        logic        ev;
        logic [31:0] ed;
        logic [5:0]  fa;
        @(negedge clk);
        f_req = rq; f_addr = {a1, a0};
        @(negedge clk);
        f_req = 2'b00;
        for (int i = 0; i < 2; i++) begin
            fa = (i == 0) ? a0 : a1;
            ev = rq[i] & emu_en[i] & !m_stop;
            ed = ev ? mem_m[fa] : 32'd0;
            check(f_valid[i] === ev && f_data[32*i +: 32] === ed, tag,
                  {31'd0, f_valid[i], f_data[32*i +: 32]}, {31'd0, ev, ed});
        end
    endtask

    function automatic logic [8:0] aa(input logic [5:0] w, input logic [1:0] lo);
        return {1'b0, w, lo};
    endfunction

    function automatic logic [8:0] ra(input logic [5:0] idx, input logic [1:0] lo);
        return {1'b1, idx, lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R8, R3)
        check(h_ack === 1'b0, "R8 no ack after reset", {63'd0, h_ack}, 64'd0);
        check(f_valid === 2'b00, "R8 fetch idle after reset", {62'd0, f_valid}, 64'd0);
        op(1'b0, 2'd2, ra(6'd0, 2'd0), 32'd0, "R3 config resets to zero");
        op(1'b0, 2'd2, ra(6'd1, 2'd0), 32'd0, "R3 depth register");

        // load the array
        for (int i = 0; i < 64; i++) op(1'b1, 2'd2, aa(6'(i), 2'd0), $urandom, "R1 word fill");
        for (int i = 0; i < 64; i += 9) op(1'b0, 2'd2, aa(6'(i), 2'd0), 32'd0, "R1 word read");

        // R1 lanes
        op(1'b1, 2'd0, aa(6'd3, 2'd1), 32'h0000_A500, "R1 byte write lane 1");
        op(1'b0, 2'd2, aa(6'd3, 2'd0), 32'd0, "R1 byte lane read back");
        op(1'b1, 2'd1, aa(6'd3, 2'd2), 32'h1234_0000, "R1 half write upper");
        op(1'b0, 2'd0, aa(6'd3, 2'd3), 32'd0, "R1 byte read returns word");

        // R2 misaligned and reserved sizes
        op(1'b1, 2'd1, aa(6'd4, 2'd1), 32'hFFFF_FFFF, "R2 odd halfword error");
        op(1'b1, 2'd2, aa(6'd4, 2'd2), 32'hFFFF_FFFF, "R2 misaligned word error");
        op(1'b0, 2'd3, aa(6'd4, 2'd0), 32'd0, "R2 reserved size error");
        op(1'b0, 2'd2, aa(6'd4, 2'd0), 32'd0, "R2 word unchanged");

        // R3 register map
        op(1'b0, 2'd2, ra(6'd2, 2'd0), 32'd0, "R3 unmapped index error");
        op(1'b1, 2'd2, ra(6'd1, 2'd0), 32'd7, "R3 depth write error");
        op(1'b1, 2'd0, ra(6'd0, 2'd1), 32'h0000_0300, "R3 lane 1 write ignored");
        op(1'b0, 2'd2, ra(6'd0, 2'd0), 32'd0, "R3 config after lane 1 write");

        // R4 disable
        op(1'b1, 2'd2, ra(6'd0, 2'd0), 32'd2, "R4 set DIS");
        op(1'b0, 2'd2, aa(6'd7, 2'd0), 32'd0, "R4 read blocked");
        op(1'b1, 2'd2, aa(6'd7, 2'd0), 32'hDEAD_0001, "R4 write blocked");
        op(1'b1, 2'd2, ra(6'd0, 2'd0), 32'd0, "R4 clear DIS");
        op(1'b0, 2'd2, aa(6'd7, 2'd0), 32'd0, "R4 word kept");

        // R5 stop
        op(1'b1, 2'd2, ra(6'd0, 2'd0), 32'd1, "R5 set STOP");
        op(1'b0, 2'd2, ra(6'd0, 2'd0), 32'd0, "R5 config readable");
        op(1'b1, 2'd1, aa(6'd8, 2'd0), 32'h0000_BEEF, "R5 array write blocked");
        op(1'b0, 2'd2, ra(6'd1, 2'd0), 32'd0, "R5 depth register blocked");
        op(1'b1, 2'd2, ra(6'd0, 2'd0), 32'd3, "R5 DIS held while stopped");
        op(1'b0, 2'd2, ra(6'd0, 2'd0), 32'd0, "R5 config after DIS attempt");
        emu_en = 2'b11;
        fetch(2'b11, 6'd8, 6'd9, "R5 fetch blocked by stop");
        emu_en = 2'b00;
        op(1'b1, 2'd2, ra(6'd0, 2'd0), 32'd0, "R5 clear STOP");
        op(1'b0, 2'd2, aa(6'd8, 2'd0), 32'd0, "R5 contents retained");

        // R6 / R7 emulation
        emu_en = 2'b01;
        op(1'b1, 2'd2, ra(6'd0, 2'd0), 32'd1, "R6 stop request under emulation");
        op(1'b0, 2'd2, ra(6'd0, 2'd0), 32'd0, "R6 refused flag set, stop clear");
        op(1'b0, 2'd2, aa(6'd10, 2'd0), 32'd0, "R7 host read blocked");
        op(1'b1, 2'd0, aa(6'd10, 2'd0), 32'h55, "R7 host write blocked");
        fetch(2'b11, 6'd10, 6'd11, "R7 only enabled port fetches");
        emu_en = 2'b11;
        fetch(2'b11, 6'd12, 6'd13, "R7 dual fetch same cycle");
        fetch(2'b10, 6'd14, 6'd15, "R7 idle port stays invalid");
        emu_en = 2'b00;
        op(1'b1, 2'd2, ra(6'd0, 2'd0), 32'd0, "R6 refused cleared");
        op(1'b0, 2'd2, ra(6'd0, 2'd0), 32'd0, "R6 config clean");
        op(1'b0, 2'd2, aa(6'd10, 2'd0), 32'd0, "R7 word untouched by blocked write");

        // R9 freeze
        freeze = 1'b1;
        op(1'b1, 2'd2, aa(6'd20, 2'd0), 32'h0F0F_1234, "R9 write under freeze");
        op(1'b0, 2'd2, aa(6'd20, 2'd0), 32'd0, "R9 read under freeze");
        freeze = 1'b0;

        // R8 reset during an access
        @(negedge clk);
        h_req = 1'b1; h_wr = 1'b1; h_size = 2'd2; h_addr = aa(6'd5, 2'd0); h_wdata = 32'hCAFE_F00D;
        @(negedge clk);
        h_req = 1'b0; rst = 1'b1;
        @(negedge clk);
        check(h_ack === 1'b1 && h_err === 1'b0, "R8 in-flight write completes",
              {62'd0, h_ack, h_err}, 64'd2);
        mem_m[5] = 32'hCAFE_F00D;
        m_stop = 1'b0; m_dis = 1'b0; m_ref = 1'b0;
        h_req = 1'b1; h_wr = 1'b1; h_size = 2'd2; h_addr = aa(6'd6, 2'd0); h_wdata = 32'h0BAD_BEEF;
        @(negedge clk);
        h_req = 1'b0;
        @(negedge clk);
        check(h_ack === 1'b0, "R8 request during reset gets no ack", {63'd0, h_ack}, 64'd0);
        @(negedge clk);
        check(h_ack === 1'b0, "R8 still no ack", {63'd0, h_ack}, 64'd0);
        rst = 1'b0;
        op(1'b0, 2'd2, aa(6'd5, 2'd0), 32'd0, "R8 in-flight write landed");
        op(1'b0, 2'd2, aa(6'd6, 2'd0), 32'd0, "R8 write during reset dropped");
        op(1'b0, 2'd2, ra(6'd0, 2'd0), 32'd0, "R8 config reset");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [8:0]  a;
            logic [1:0]  sz;
            logic [31:0] wd;
            logic        wr;
            if ($urandom % 10 == 0) emu_en = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
            freeze = 1'($urandom);
            wr = 1'($urandom);
            sz = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
            wd = $urandom;
            if ($urandom % 16 < 3) begin
                a = ra(6'($urandom % 3), 2'($urandom));
                wd = wd & (($urandom % 4 == 0) ? 32'hF : 32'h2);
            end else begin
                a = aa(6'($urandom), 2'($urandom));
            end
            op(wr, sz, a, wd, "random R1 R2 R3 R4 R5 R6 R7 R9");
            if (n % 5 == 0) fetch(2'($urandom), 6'($urandom), 6'($urandom), "random R7 fetch");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule